// File: doc/BRIEF.md
# Grouped Interrupt Flag Multiplexer

The block gathers up to sixteen interrupt request bits and drives four CPU interrupt lines from them. Bits 1 to 14 are live request inputs, and bits 0 and 15 are reserved. Each request input passes through a two-flop synchronizer. A rising edge on a live input latches a bit in a flag register. A mask register on the same bus gates each flagged source off or on.

Each of the four interrupt lines is tied to a fixed group of flag bits, and the bits of a group are not contiguous. A line is high whenever at least one bit of its group is flagged and not masked. Software clears flags by writing zeros to the flag register: to clear a set of sources, it writes the complement of that set. The mask register comes out of reset with every live source disabled.

Register access uses a single-cycle port. A write is taken on the clock edge where select and write-enable are both high. Reads are combinational on the address. The asynchronous active-low reset is released in step with the clock through an internal two-flop stage.

Top module: `irq_group_mux`

## Requirements
- R1: After reset, the mask register reads 0x7FFE, the flag register reads 0x0000 and all four interrupt lines are low.
- R2: A rising edge on request bit i, for i from 1 to 14, sets flag bit i three clock edges after the input rises. A request held high does not set its flag again after that flag has been cleared.
- R3: A write to the flag register at address 0xC clears each flag bit written as 0 and leaves each bit written as 1 unchanged.
- R4: If a flag write clears a bit on the same edge on which that bit's request edge arrives, the bit ends up set.
- R5: The mask register at address 0x4 stores all 16 written bits and reads them back. A 1 in bit i disables source i and a 0 enables it.
- R6: Line 0 serves bits 3 and 5 (0x0028). Line 1 serves bits 4 and 6 (0x0050). Line 2 serves bits 10 to 12 (0x1C00). Line 3 serves bits 1, 2, 7, 8, 9, 13 and 14 (0x6386). Each line is the OR over its group of flag AND NOT mask.
- R7: Request bits 0 and 15 never set a flag and never drive a line, and both bits read as 0 in the flag register.
- R8: The interrupt lines are registered. A line changes on the first clock edge after the flag or mask change that causes the change.
- R9: Reads from any address other than 0x4 and 0xC return 0, and writes to such addresses change neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Request inputs; bits 0 and 15 are unused |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write enable |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, combinational on the address |
| irq_o | output | 4 | Interrupt lines to the CPU |

## Verification
The bench drives inputs at the falling edge and samples at the following falling edge. With that scheme, a request that rises shows in the flag read after three rising edges and on its interrupt line after four. A register write shows in the read data one edge after it is issued and on the lines one edge later. Each check samples at exactly that edge and also checks that the line has not yet moved one edge earlier. For the set-beats-clear case, the bench issues the clearing write so that it lands on the same edge as the detected request edge.

// File: rtl/irq_mux_pkg.sv
package irq_mux_pkg;
  localparam int DATA_W    = 16;
  localparam int ADDR_W    = 4;
  localparam int NUM_LINES = 4;
  localparam int SYNC_STG  = 2;

  localparam logic [ADDR_W-1:0] MASK_ADDR = 4'h4;
  localparam logic [ADDR_W-1:0] FLAG_ADDR = 4'hC;

  localparam logic [DATA_W-1:0] LINE_GROUP [NUM_LINES] = '{
    16'h0028, 16'h0050, 16'h1C00, 16'h6386
  };

  function automatic logic [DATA_W-1:0] live_bits();
    logic [DATA_W-1:0] acc;
    acc = '0;
    for (int n = 0; n < NUM_LINES; n++) acc |= LINE_GROUP[n];
    return acc;
  endfunction

  localparam logic [DATA_W-1:0] LIVE_MASK = live_bits();
endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
  parameter int WIDTH  = 16,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] rise_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES:0] pipe_q, pipe_d;

    always_comb pipe_d = {pipe_q[STAGES-1:0], req_i[b]};

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pipe_q <= '0;
      else         pipe_q <= pipe_d;
    end

    assign rise_o[b] = pipe_q[STAGES-1] & ~pipe_q[STAGES];

    // R2: a detected edge lasts exactly one cycle
    a_r2_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise_o[b] |=> !rise_o[b]);
  end
endmodule

// File: rtl/irq_regfile.sv
module irq_regfile
  import irq_mux_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] rise_i,
  output logic [DATA_W-1:0] mask_o,
  output logic [DATA_W-1:0] flag_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [DATA_W-1:0] MASK_RST = LIVE_MASK;

  logic [DATA_W-1:0] mask_q, mask_d, flag_q, flag_d, set_v;
  logic              wr_mask, wr_flag;

  assign wr_mask = sel_i & we_i & (addr_i == MASK_ADDR);
  assign wr_flag = sel_i & we_i & (addr_i == FLAG_ADDR);
  assign set_v   = rise_i & LIVE_MASK;

  always_comb begin
    mask_d = mask_q;
    if (wr_mask) mask_d = wdata_i;
    flag_d = flag_q;
    if (wr_flag) flag_d = flag_q & wdata_i;
    flag_d = (flag_d | set_v) & LIVE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_RST;
      flag_q <= '0;
    end else begin
      if (wr_mask) mask_q <= mask_d;
      flag_q <= flag_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == MASK_ADDR) rdata_o = mask_q;
    if (addr_i == FLAG_ADDR) rdata_o = flag_q;
  end

  assign mask_o = mask_q;
  assign flag_o = flag_q;

  // R4: a captured edge is never lost, even to a clearing write
  a_r4_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_v != '0) |=> ((flag_q & $past(set_v)) == $past(set_v)));
  // R3: bits written as zero and not re-set end up clear
  a_r3_zero_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_flag |=> ((flag_q & ~$past(wdata_i) & ~$past(set_v)) == '0));
  // R5: mask holds the written word
  a_r5_mask_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_mask |=> (mask_q == $past(wdata_i)));
  // R9: no access to the mask leaves it alone
  a_r9_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mask |=> $stable(mask_q));
  // R7: reserved flag bits stay clear
  a_r7_reserved_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q[0] == 1'b0) && (flag_q[DATA_W-1] == 1'b0));
endmodule

// File: rtl/irq_line_drv.sv
module irq_line_drv
  import irq_mux_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    flag_i,
  input  logic [DATA_W-1:0]    mask_i,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [DATA_W-1:0] pend;
  assign pend = flag_i & ~mask_i;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic hit, irq_q;
    assign hit = |(pend & LINE_GROUP[n]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= hit;
    end

    assign irq_o[n] = irq_q;

    // R8: a line rises only after a pending group bit was seen
    a_r8_rise_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_q) |-> $past((flag_i & ~mask_i & LINE_GROUP[n]) != '0));
    // R6: a line drops only once its group has nothing pending
    a_r6_fall_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(irq_q) |-> $past((flag_i & ~mask_i & LINE_GROUP[n]) == '0));
  end
endmodule

// File: rtl/irq_group_mux.sv
module irq_group_mux
  import irq_mux_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [DATA_W-1:0]    req_i,
  input  logic                 bus_sel_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [DATA_W-1:0]    bus_wdata_i,
  output logic [DATA_W-1:0]    bus_rdata_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_n_int;
  logic [DATA_W-1:0] rise, mask, flag;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  irq_req_sync #(.WIDTH(DATA_W), .STAGES(SYNC_STG)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_n_int), .req_i(req_i), .rise_o(rise)
  );

  irq_regfile u_regs (
    .clk_i(clk_i), .rst_ni(rst_n_int), .sel_i(bus_sel_i), .we_i(bus_we_i),
    .addr_i(bus_addr_i), .wdata_i(bus_wdata_i), .rise_i(rise),
    .mask_o(mask), .flag_o(flag), .rdata_o(bus_rdata_o)
  );

  irq_line_drv u_lines (
    .clk_i(clk_i), .rst_ni(rst_n_int), .flag_i(flag), .mask_i(mask), .irq_o(irq_o)
  );

  // R7: reserved bits never drive a line
  a_r7_no_reserved_irq: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ((flag & ~mask & 16'h7FFE) == '0) |=> (irq_o == '0));
endmodule

// File: tb/test_irq_group_mux.sv
module test_irq_group_mux;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [15:0] req_i;
  logic        bus_sel_i, bus_we_i;
  logic [3:0]  bus_addr_i;
  logic [15:0] bus_wdata_i;
  logic [15:0] bus_rdata_o;
  logic [3:0]  irq_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] grp [4] = '{16'h0028, 16'h0050, 16'h1C00, 16'h6386};

  always #2 clk_i = ~clk_i;

  irq_group_mux i_irq_group_mux (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk_i);
    bus_sel_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
    bus_sel_i = 1'b0; bus_we_i = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, output logic [15:0] d);
    bus_addr_i = a;
    #0.5;
    d = bus_rdata_o;
  endtask

  function automatic logic [3:0] lines(input logic [15:0] f, input logic [15:0] m);
    logic [3:0] r;
    for (int n = 0; n < 4; n++) r[n] = |(f & ~m & grp[n]);
    return r;
  endfunction

  // drive a rising edge at a falling edge; returns at the falling edge after 3 rising edges
  task automatic pulse_req(input int b);
    @(negedge clk_i);
    req_i[b] = 1'b1;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  logic [15:0] rd;

  initial begin
    int hung = 0;
    fork
      begin
        rst_ni = 1'b0; req_i = '0; bus_sel_i = 0; bus_we_i = 0;
        bus_addr_i = '0; bus_wdata_i = '0;
        repeat (3) @(posedge clk_i);
        @(negedge clk_i); rst_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        // R1 reset state
        bus_rd(4'h4, rd); chk("R1 mask", rd, 16'h7FFE);
        bus_rd(4'hC, rd); chk("R1 flag", rd, 16'h0000);
        chk("R1 irq", {12'h0, irq_o}, 16'h0);

        // R2/R6/R7/R8 sweep over all bits with all sources enabled
        bus_wr(4'h4, 16'h0000);
        for (int b = 0; b < 16; b++) begin
          logic [15:0] ef;
          ef = ((b >= 1) && (b <= 14)) ? (16'h1 << b) : 16'h0;
          pulse_req(b);
          bus_rd(4'hC, rd); chk("R2/R7 flag set", rd, ef);
          chk("R8 irq not yet", {12'h0, irq_o}, 16'h0);
          @(negedge clk_i);
          chk("R6/R7 irq line", {12'h0, irq_o}, {12'h0, lines(ef, 16'h0)});
          // R5 masking this source drops its line one edge after the write
          bus_wr(4'h4, 16'h1 << b);
          bus_rd(4'h4, rd); chk("R5 mask readback", rd, 16'h1 << b);
          chk("R8 irq still old", {12'h0, irq_o}, {12'h0, lines(ef, 16'h0)});
          @(negedge clk_i);
          chk("R5 masked irq low", {12'h0, irq_o}, 16'h0);
          bus_wr(4'h4, 16'h0000);
          // R3 clear by writing complement, request still held high
          bus_wr(4'hC, ~(16'h1 << b));
          bus_rd(4'hC, rd); chk("R3 flag cleared", rd, 16'h0);
          repeat (4) @(negedge clk_i);
          bus_rd(4'hC, rd); chk("R2 held level no reset", rd, 16'h0);
          chk("R3 irq low", {12'h0, irq_o}, 16'h0);
          req_i[b] = 1'b0;
          repeat (3) @(negedge clk_i);
        end

        // R3 writing ones keeps bits; multi-source OR per line
        pulse_req(3); pulse_req(10); pulse_req(14);
        bus_rd(4'hC, rd); chk("R2 multi flag", rd, 16'h4408);
        bus_wr(4'hC, 16'hFFFF);
        bus_rd(4'hC, rd); chk("R3 ones keep", rd, 16'h4408);
        @(negedge clk_i);
        chk("R6 multi lines", {12'h0, irq_o}, 16'h000D);
        bus_wr(4'hC, 16'hBFFF);
        bus_rd(4'hC, rd); chk("R3 partial clear", rd, 16'h0408);
        @(negedge clk_i);
        chk("R6 after partial", {12'h0, irq_o}, 16'h0005);

        // R9 off-map access
        bus_wr(4'h0, 16'h0000);
        bus_wr(4'h8, 16'hFFFF);
        bus_rd(4'h4, rd); chk("R9 mask untouched", rd, 16'h0000);
        bus_rd(4'hC, rd); chk("R9 flag untouched", rd, 16'h0408);
        bus_rd(4'h8, rd); chk("R9 read other", rd, 16'h0000);
        bus_rd(4'h0, rd); chk("R9 read zero addr", rd, 16'h0000);

        // R4 set beats a clear on the same edge
        req_i = '0;
        repeat (3) @(negedge clk_i);
        @(negedge clk_i);
        req_i[5] = 1'b1;
        @(posedge clk_i); @(posedge clk_i);
        @(negedge clk_i);
        bus_sel_i = 1; bus_we_i = 1; bus_addr_i = 4'hC; bus_wdata_i = 16'h0000;
        @(posedge clk_i);
        @(negedge clk_i);
        bus_sel_i = 0; bus_we_i = 0;
        bus_rd(4'hC, rd); chk("R4 set wins", rd, 16'h0020);

        // R1 reset again restores state
        @(negedge clk_i); rst_ni = 1'b0;
        @(negedge clk_i); rst_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        bus_rd(4'h4, rd); chk("R1 mask after reset", rd, 16'h7FFE);
        bus_rd(4'hC, rd); chk("R1 flag after reset", rd, 16'h0000);
      end
      begin
        repeat (100000) @(posedge clk_i);
        hung = 1;
      end
    join_any
    disable fork;
    if (hung != 0) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule